// File: doc/BRIEF.md
# I2C Configuration Target with Voted Storage

This block is the slow-control port of a front-end chip. It sits on a shared two-wire bus as a standard-mode target and holds a small bank of byte-wide parameter registers that steer the rest of the chip. Each chip answers its own 7-bit geographic address, which comes from board-level pins, so up to 127 chips can share one pair of wires. All chips also answer address 0x00, so one write can load the same setting into every chip at once.

Every register is kept in three copies. The parameter outputs and all read-back data come from a bitwise two-out-of-three vote. A background scrubber walks through the registers one per clock and rewrites all three copies of the visited register with its voted value, so an upset in one copy is repaired before a second upset can hit a different copy of the same bit. Reads never disturb the registers and may be issued at any time, including during data taking.

Frames carry a register-index byte after the address byte. A write frame is START, address+W, index, data, STOP. A read frame is START, address+W, index, repeated START, address+R, one data byte from the target, master NACK, STOP. SCL and SDA are brought into the clock domain through two flops each. The pad is modelled as an SDA pull-down enable. Upset-injection inputs let a copy bit be flipped to model a single-event upset.

Top module: `cfg_i2c_target`

## Requirements
- R1: While reset is asserted, and right after it is released, `sda_oe` is 0 and every register reads RST_VAL (0x3C by default) on `cfg_out`. Register i occupies `cfg_out[8*i +: 8]`.
- R2: An address byte whose upper seven bits equal a non-zero `geo_addr` and whose bit 0 (R/W) is 0 is ACKed. The index byte and the data byte that follow are also ACKed, and after the data byte the data appears on `cfg_out` for that index.
- R3: An address byte that matches neither `geo_addr` nor 0x00 is NACKed: SDA is not pulled low in its ACK slot, and no register changes.
- R4: Address 0x00 with R/W = 0 is ACKed by every chip whatever its `geo_addr`, and its index and data bytes write that chip's register just as R2 does.
- R5: Address 0x00 with R/W = 1 is NACKed and the target never drives SDA for it, so the master sees 0xFF.
- R6: A read frame to the chip's own address returns the voted value of the last indexed register, MSB first. The target releases SDA during the master's NACK bit that follows. Reading changes no register.
- R7: An index of NUM_REGS or above is still ACKed, but a write to it changes no register and a read from it returns 0x00.
- R8: Flipping any single bit in any one of the three copies leaves `cfg_out` and the read-back value unchanged.
- R9: Within NUM_REGS clocks of an upset, the scrubber restores the flipped copy. A later flip of another copy of the same bit therefore also leaves the voted value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_addr | input | 7 | Geographic bus address of this chip (1 to 127) |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain model) |
| flip_req | input | 1 | Upset injection strobe, one cycle |
| flip_copy | input | 2 | Copy to upset (0 to 2; 3 does nothing) |
| flip_reg | input | 8 | Register index to upset |
| flip_bit | input | 3 | Bit position to upset |
| cfg_out | output | 8*NUM_REGS | Voted parameter bytes, register i at bits 8*i+7..8*i |

## Verification
The address byte is swept over all 128 values with write direction, which separates the own-address ACK, the broadcast ACK and the NACK of every foreign address. Writes and read-backs are repeated for several geographic addresses with a data value computed from both the address and the index, so a wrong register or a wrong chip match gives a visibly different byte. Broadcast reads and out-of-range indices probe the refusal paths. A sweep flips every bit of every register in one copy after another, spaced past one scrub round, which separates plain voting from voting plus repair: without the scrubber, the second copy's flips would change the vote.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] RST_VAL  = 8'h3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [6:0]            geo_addr,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic                  flip_req,
  input  logic [1:0]            flip_copy,
  input  logic [7:0]            flip_reg,
  input  logic [2:0]            flip_bit,
  output logic [8*NUM_REGS-1:0] cfg_out
);
  localparam int RIW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_RGACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } state_t;

  state_t         state;
  logic [1:0]     scl_sy, sda_sy;
  logic           scl_q, sda_q;
  logic           scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]     sr, tx, ptr;
  logic [3:0]     cnt;
  logic           bc_q, rw_q;
  logic           addr_own, addr_bc, ptr_ok, wr_en;
  logic [7:0]     rd_byte;
  logic [7:0]     cp    [3][NUM_REGS];
  logic [7:0]     voted [NUM_REGS];
  logic [RIW-1:0] sp, sp_q;

  // pad synchronisers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  assign scl_rise = scl_sy[1] & ~scl_q;
  assign scl_fall = ~scl_sy[1] & scl_q;
  assign start_c  = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
  assign stop_c   = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];

  assign addr_own = (sr[7:1] == geo_addr) && (geo_addr != 7'd0);
  assign addr_bc  = (sr[7:1] == 7'd0) && !sr[0];
  assign ptr_ok   = 32'(ptr) < NUM_REGS;
  assign rd_byte  = ptr_ok ? voted[ptr[RIW-1:0]] : 8'h00;
  assign wr_en    = (state == S_WDAT) && scl_fall && (cnt == 4'd8) && ptr_ok;

  // protocol engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      cnt    <= '0;
      bc_q   <= 1'b0;
      rw_q   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (scl_rise && (state inside {S_ADDR, S_REG, S_WDAT})) begin
        sr  <= {sr[6:0], sda_sy[1]};
        cnt <= cnt + 4'd1;
      end
      case (state)
        S_ADDR: if (scl_fall && cnt == 4'd8) begin
          cnt <= '0;
          if (addr_own || addr_bc) begin
            sda_oe <= 1'b1;
            rw_q   <= sr[0];
            bc_q   <= addr_bc;
            state  <= S_AACK;
          end else begin
            state  <= S_IDLE;
          end
        end
        S_AACK: if (scl_fall) begin
          if (rw_q) begin
            state  <= S_RDAT;
            tx     <= {rd_byte[6:0], 1'b0};
            sda_oe <= ~rd_byte[7];
          end else begin
            state  <= S_REG;
            sda_oe <= 1'b0;
          end
        end
        S_REG: if (scl_fall && cnt == 4'd8) begin
          ptr    <= sr;
          cnt    <= '0;
          sda_oe <= 1'b1;
          state  <= S_RGACK;
        end
        S_RGACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= S_WDAT;
        end
        S_WDAT: if (scl_fall && cnt == 4'd8) begin
          cnt    <= '0;
          sda_oe <= 1'b1;
          state  <= S_WACK;
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= S_SKIP;
        end
        S_RDAT: if (scl_fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0;
            state  <= S_RACK;
          end else begin
            sda_oe <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
            cnt    <= cnt + 4'd1;
          end
        end
        S_RACK: if (scl_rise) state <= S_SKIP;
        default: ;
      endcase
    end
  end

  // voted readout
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_vote
    assign voted[i] = (cp[0][i] & cp[1][i]) | (cp[0][i] & cp[2][i]) | (cp[1][i] & cp[2][i]);
    assign cfg_out[8*i +: 8] = voted[i];
  end

  // triple storage, scrubber, upset model
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < NUM_REGS; i++)
          cp[k][i] <= RST_VAL;
      sp   <= '0;
      sp_q <= '0;
    end else begin
      sp   <= (sp == RIW'(NUM_REGS - 1)) ? '0 : sp + 1'b1;
      sp_q <= sp;
      for (int k = 0; k < 3; k++) cp[k][sp] <= voted[sp];
      if (flip_req && flip_copy != 2'd3 && 32'(flip_reg) < NUM_REGS)
        cp[flip_copy][flip_reg[RIW-1:0]][flip_bit] <= ~cp[flip_copy][flip_reg[RIW-1:0]][flip_bit];
      if (wr_en)
        for (int k = 0; k < 3; k++) cp[k][ptr[RIW-1:0]] <= sr;
    end
  end

  AST_OE_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_sy[1]); // R2
  AST_OE_ONLY_WHEN_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {S_AACK, S_RGACK, S_WACK, S_RDAT})); // R6
  AST_NO_BCAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT) |-> !bc_q); // R5
  AST_CFG_CHANGES_ONLY_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> ($past(wr_en) || $past(flip_req))); // R7
  AST_SCRUB_REPAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flip_req) |-> (cp[0][sp_q] == cp[1][sp_q] && cp[1][sp_q] == cp[2][sp_q])); // R9
endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 8;
  localparam int         NREG       = 8;
  localparam logic [7:0] RSTV       = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sda_bus;
  logic [6:0] geo = 7'h2A;
  logic sda_oe;
  logic flip_req = 1'b0;
  logic [1:0] flip_copy = '0;
  logic [7:0] flip_reg = '0;
  logic [2:0] flip_bit = '0;
  logic [8*NREG-1:0] cfg;
  logic [7:0] expv [NREG];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_target #(.NUM_REGS(NREG), .RST_VAL(RSTV)) i_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .geo_addr(geo), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .flip_req(flip_req), .flip_copy(flip_copy), .flip_reg(flip_reg),
    .flip_bit(flip_bit), .cfg_out(cfg));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [8*NREG-1:0] exp_cfg();
    logic [8*NREG-1:0] r;
    for (int i = 0; i < NREG; i++) r[8*i +: 8] = expv[i];
    return r;
  endfunction

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_w(input logic b);
    sda_m = b; wt(HALF); scl_m = 1'b1; wt(HALF); scl_m = 1'b0; wt(2);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF/2); b = sda_bus; wt(HALF/2);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic cond_start();
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic cond_stop();
    sda_m = 1'b0; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
  endtask

  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b);
    ack = ~b;
  endtask

  task automatic byte_r(output logic [7:0] d, output logic released);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_r(released);
  endtask

  task automatic wr_frame(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                          output logic [2:0] acks);
    acks = '0;
    cond_start();
    byte_w({a, 1'b0}, acks[2]);
    if (acks[2]) begin
      byte_w(r, acks[1]);
      if (acks[1]) byte_w(d, acks[0]);
    end
    cond_stop();
  endtask

  task automatic rd_frame(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d,
                          output logic [2:0] acks, output logic rel);
    acks = '0; d = 8'hFF; rel = 1'b1;
    cond_start();
    byte_w({a, 1'b0}, acks[2]);
    if (acks[2]) begin
      byte_w(r, acks[1]);
      cond_start();
      byte_w({a, 1'b1}, acks[0]);
      if (acks[0]) byte_r(d, rel);
    end
    cond_stop();
  endtask

  task automatic upset(input int k, input int r, input int b);
    flip_copy = 2'(k); flip_reg = 8'(r); flip_bit = 3'(b); flip_req = 1'b1;
    wt(1); flip_req = 1'b0; wt(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic rel, ack;
    for (int i = 0; i < NREG; i++) expv[i] = RSTV;
    wt(3);
    check(sda_oe == 1'b0, "R1", "sda_oe in reset", 64'(sda_oe), 64'd0);
    rst_n = 1'b1; wt(3);
    check(cfg == exp_cfg(), "R1", "cfg after reset", cfg, exp_cfg());
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", 64'(sda_oe), 64'd0);

    // address sweep, write direction
    geo = 7'h2A;
    for (int a = 0; a < 128; a++) begin
      cond_start();
      byte_w({7'(a), 1'b0}, ack);
      cond_stop();
      if (a == 0)          check(ack == 1'b1, "R4", "bcast addr ack", 64'(ack), 64'd1);
      else if (a == 'h2A)  check(ack == 1'b1, "R2", "own addr ack", 64'(ack), 64'd1);
      else                 check(ack == 1'b0, "R3", "foreign addr nack", 64'(ack), 64'd0);
    end
    check(cfg == exp_cfg(), "R3", "cfg after addr sweep", cfg, exp_cfg());

    // writes and reads for several geographic addresses
    for (int gi = 0; gi < 4; gi++) begin
      logic [6:0] g;
      g = (gi == 0) ? 7'h01 : (gi == 1) ? 7'h2A : (gi == 2) ? 7'h55 : 7'h7F;
      geo = g;
      for (int r = 0; r < NREG; r++) begin
        logic [7:0] v;
        v = 8'(int'(g) * 13 + r * 29 + 7);
        wr_frame(g, 8'(r), v, acks);
        check(acks == 3'b111, "R2", "write acks", 64'(acks), 64'h7);
        expv[r] = v;
        check(cfg == exp_cfg(), "R2", "cfg after write", cfg, exp_cfg());
      end
      for (int r = 0; r < NREG; r++) begin
        rd_frame(g, 8'(r), d, acks, rel);
        check(acks == 3'b111, "R6", "read acks", 64'(acks), 64'h7);
        check(d == expv[r], "R6", "read data", 64'(d), 64'(expv[r]));
        check(rel == 1'b1, "R6", "release after data", 64'(rel), 64'd1);
      end
      check(cfg == exp_cfg(), "R6", "cfg after reads", cfg, exp_cfg());
      wr_frame(g ^ 7'h01 ^ ((g == 7'h01) ? 7'h02 : 7'h00), 8'd0, 8'hEE, acks);
      check(acks == 3'b000, "R3", "foreign write nack", 64'(acks), 64'h0);
      check(cfg == exp_cfg(), "R3", "cfg after foreign write", cfg, exp_cfg());
    end

    // broadcast writes
    geo = 7'h33;
    for (int r = 0; r < NREG; r++) begin
      logic [7:0] v;
      v = 8'(r * 47 + 5) ^ 8'hC3;
      wr_frame(7'h00, 8'(r), v, acks);
      check(acks == 3'b111, "R4", "bcast write acks", 64'(acks), 64'h7);
      expv[r] = v;
    end
    check(cfg == exp_cfg(), "R4", "cfg after bcast", cfg, exp_cfg());
    rd_frame(7'h33, 8'd6, d, acks, rel);
    check(d == expv[6], "R4", "bcast value read back", 64'(d), 64'(expv[6]));

    // broadcast read is refused
    rd_frame(7'h00, 8'd3, d, acks, rel);
    check(acks == 3'b110, "R5", "bcast read addr nack", 64'(acks), 64'h6);
    check(d == 8'hFF, "R5", "bcast read bus idle", 64'(d), 64'hFF);

    // out-of-range index
    wr_frame(7'h33, 8'd8, 8'h99, acks);
    check(acks == 3'b111, "R7", "oor write acks", 64'(acks), 64'h7);
    wr_frame(7'h33, 8'hFF, 8'h99, acks);
    check(cfg == exp_cfg(), "R7", "cfg after oor writes", cfg, exp_cfg());
    rd_frame(7'h33, 8'd8, d, acks, rel);
    check(acks == 3'b111 && d == 8'h00, "R7", "oor read", 64'({acks, d}), 64'({3'b111, 8'h00}));

    // single upsets in every copy, spaced past one scrub round
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < NREG; r++)
        for (int b = 0; b < 8; b++) begin
          upset(k, r, b);
          check(cfg == exp_cfg(), (k == 0) ? "R8" : "R9", "cfg after upset", cfg, exp_cfg());
          wt(NREG + 4);
        end
    rd_frame(7'h33, 8'd5, d, acks, rel);
    check(d == expv[5], "R8", "read after upsets", 64'(d), 64'(expv[5]));

    // explicit repair sequence on one bit
    upset(0, 2, 5); wt(NREG + 4);
    upset(1, 2, 5); wt(NREG + 4);
    upset(2, 2, 5); wt(NREG + 4);
    check(cfg == exp_cfg(), "R9", "cfg after staggered upsets", cfg, exp_cfg());

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule